// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block looks at two groups of pending interrupt requests, a software request word and an external status word, and places both on one shared priority scale. Software request bits give the low levels and external bits give the high levels. The highest level that is pending wins. The block compares the winner with the current interrupt priority level and raises a trap only when the winner is strictly higher.

When a trap is taken, the block registers a one-cycle trap strobe. On the same edge it latches two values: a mask of every in-range pending bit it saw, and the level of the winner. Both held values stay unchanged until the next trap.

After a trap the arbiter is disarmed. A trap handler raises the acknowledge input to allow the next trap, so a request that is still pending cannot cause a second trap straight away. Asynchronous-trap requests are not serviced. A nonzero request of that kind only raises an error flag.

Top module: `irq_level_arbiter`

## Requirements
- R1: A software request bit at index i, with 1 <= i <= 15, maps to level i. When several are set, the highest index wins.
- R2: An external bit at index i, with 16 <= i <= 31, maps to level i. When any external bit in range is set, the highest set external bit wins over every software bit.
- R3: Request bits outside their range are ignored and have no effect on any output. These are software bits 0 and 16 to 31, and external bits 0 to 15.
- R4: The summary output, bit for bit, holds every in-range software and external bit that was pending when the trap was taken, at its own bit position.
- R5: A trap is taken only when the winning level is nonzero and strictly greater than `cur_ipl`. An equal or lower level gives no trap.
- R6: `trap_pulse` is high for exactly one cycle, on the clock edge after the qualifying inputs. `int_id` and `isr_summary` update on that same edge.
- R7: `int_id` and `isr_summary` keep their values in every cycle in which no trap is taken.
- R8: After a trap, no further trap is taken until `trap_ack` has been high at one clock edge. The trap can come at the earliest on the edge after that one.
- R9: `ast_err` is high on the edge after any nonzero `ast_req` and low on the edge after `ast_req` returns to zero. `ast_req` never starts a trap.
- R10: While reset is active, `trap_pulse`, `int_id`, `isr_summary` and `ast_err` are 0. The arbiter leaves reset armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 32 | Software interrupt request word |
| ext_req | input | 32 | External interrupt status word |
| cur_ipl | input | 5 | Current interrupt priority level |
| ast_req | input | 4 | Asynchronous-trap request (not serviced) |
| trap_ack | input | 1 | Handler acknowledge that re-arms the arbiter |
| trap_pulse | output | 1 | One-cycle trap strobe |
| isr_summary | output | 32 | Pending mask latched at the last trap |
| int_id | output | 5 | Winning level latched at the last trap |
| ast_err | output | 1 | Asynchronous-trap request seen |

## Verification
A wrong arming state shows within one cycle. The trap strobe either repeats on the edge after a trap, or it is missing on the edge after an acknowledge while a qualifying request is still pending. A wrong scan order or level mapping shows on the trap edge itself: `int_id` holds the wrong level, or `isr_summary` has a bit set or cleared at the wrong position. A broken hold path shows in the first trap-free cycle, when `int_id` or `isr_summary` changes without a strobe.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   // Level mapping variants for a request range
   typedef enum logic [0:0] {
      MAP_OFFSET = 1'b0,   // level = index - range_low + 1
      MAP_DIRECT = 1'b1    // level = index
   } map_kind_e;

   localparam int DEF_VEC_W  = 32;
   localparam int DEF_LVL_W  = 5;
   localparam int DEF_SW_LO  = 1;
   localparam int DEF_SW_HI  = 16;
   localparam int DEF_EXT_LO = 16;
   localparam int DEF_EXT_HI = 32;
   localparam int DEF_AST_W  = 4;
endpackage

// File: rtl/irq_range_scan.sv
module irq_range_scan
   import irq_arb_pkg::*;
#(
   parameter int        VEC_W = DEF_VEC_W,
   parameter int        LO    = DEF_SW_LO,
   parameter int        HI    = DEF_SW_HI,
   parameter int        LVL_W = DEF_LVL_W,
   parameter map_kind_e MAP   = MAP_OFFSET
) (
   input  logic [VEC_W-1:0] req,
   output logic             found,
   output logic [LVL_W-1:0] level,
   output logic [VEC_W-1:0] seen
);
   // in-range mask: bits outside [LO, HI) never reach the result
   for (genvar i = 0; i < VEC_W; i++) begin : g_mask
      if (i >= LO && i < HI) begin : g_in
         assign seen[i] = req[i];
      end else begin : g_out
         assign seen[i] = 1'b0;
      end
   end

   assign found = |seen;

   // ascending scan, later (higher) set bits override earlier ones
   if (MAP == MAP_OFFSET) begin : g_offset
      always_comb begin
         level = '0;
         for (int i = LO; i < HI; i++) begin
            if (seen[i]) level = LVL_W'(i - LO + 1);
         end
      end
   end else begin : g_direct
      always_comb begin
         level = '0;
         for (int i = LO; i < HI; i++) begin
            if (seen[i]) level = LVL_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl #(
   parameter int VEC_W = 32,
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] cand_level,
   input  logic [VEC_W-1:0] cand_mask,
   input  logic [LVL_W-1:0] cur_ipl,
   input  logic             ack,
   output logic             trap_q,
   output logic [LVL_W-1:0] id_q,
   output logic [VEC_W-1:0] sum_q
);
   logic armed;
   logic fire;

   assign fire = armed && (cand_level != '0) && (cand_level > cur_ipl);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed  <= 1'b1;
         trap_q <= 1'b0;
         id_q   <= '0;
         sum_q  <= '0;
      end else begin
         trap_q <= fire;
         if (fire) begin
            armed <= 1'b0;
            id_q  <= cand_level;
            sum_q <= cand_mask;
         end else if (ack) begin
            armed <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
   import irq_arb_pkg::*;
#(
   parameter int VEC_W  = DEF_VEC_W,
   parameter int LVL_W  = DEF_LVL_W,
   parameter int SW_LO  = DEF_SW_LO,
   parameter int SW_HI  = DEF_SW_HI,
   parameter int EXT_LO = DEF_EXT_LO,
   parameter int EXT_HI = DEF_EXT_HI,
   parameter int AST_W  = DEF_AST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] sw_req,
   input  logic [VEC_W-1:0] ext_req,
   input  logic [LVL_W-1:0] cur_ipl,
   input  logic [AST_W-1:0] ast_req,
   input  logic             trap_ack,
   output logic             trap_pulse,
   output logic [VEC_W-1:0] isr_summary,
   output logic [LVL_W-1:0] int_id,
   output logic             ast_err
);
   localparam int MAX_LVL    = (1 << LVL_W) - 1;
   localparam int SW_TOP_LVL = SW_HI - SW_LO;

   // elaboration-time parameter checks
   if (SW_LO < 0 || SW_LO >= SW_HI || SW_HI > VEC_W) begin : g_bad_sw
      $error("software range invalid");
   end
   if (EXT_LO < 0 || EXT_LO >= EXT_HI || EXT_HI > VEC_W) begin : g_bad_ext
      $error("external range invalid");
   end
   if (EXT_HI - 1 > MAX_LVL || SW_TOP_LVL > MAX_LVL) begin : g_bad_lvl
      $error("level width too small");
   end
   if (EXT_LO <= SW_TOP_LVL) begin : g_bad_order
      $error("external levels must lie above software levels");
   end
   if (AST_W < 1) begin : g_bad_ast
      $error("asynchronous request width must be positive");
   end

   logic             sw_found, ext_found;
   logic [LVL_W-1:0] sw_level, ext_level, win_level;
   logic [VEC_W-1:0] sw_seen, ext_seen;
   logic             ast_q;

   irq_range_scan #(
      .VEC_W(VEC_W), .LO(SW_LO), .HI(SW_HI), .LVL_W(LVL_W), .MAP(MAP_OFFSET)
   ) u_sw_scan (
      .req(sw_req), .found(sw_found), .level(sw_level), .seen(sw_seen)
   );

   irq_range_scan #(
      .VEC_W(VEC_W), .LO(EXT_LO), .HI(EXT_HI), .LVL_W(LVL_W), .MAP(MAP_DIRECT)
   ) u_ext_scan (
      .req(ext_req), .found(ext_found), .level(ext_level), .seen(ext_seen)
   );

   // external scan runs after software: any external hit overrides
   always_comb begin
      win_level = sw_found ? sw_level : '0;
      if (ext_found) win_level = ext_level;
   end

   irq_trap_ctrl #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cand_level(win_level),
      .cand_mask (sw_seen | ext_seen),
      .cur_ipl   (cur_ipl),
      .ack       (trap_ack),
      .trap_q    (trap_pulse),
      .id_q      (int_id),
      .sum_q     (isr_summary)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ast_q <= 1'b0;
      else        ast_q <= |ast_req;
   end
   assign ast_err = ast_q;
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
   parameter int VEC_W = 32,
   parameter int LVL_W = 5,
   parameter int AST_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] cur_ipl,
   input logic [AST_W-1:0] ast_req,
   input logic             trap_ack,
   input logic             trap_pulse,
   input logic [VEC_W-1:0] isr_summary,
   input logic [LVL_W-1:0] int_id,
   input logic             ast_err
);
   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |=> !trap_pulse);

   assert_level_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> (int_id != '0) && (int_id > $past(cur_ipl)));

   assert_summary_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> (isr_summary != '0));

   assert_hold_values_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_pulse |-> ($stable(int_id) && $stable(isr_summary)));

   assert_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pulse && !trap_ack) |=> !trap_pulse);

   assert_ast_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (ast_err == (|$past(ast_req))));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
   .VEC_W(VEC_W), .LVL_W(LVL_W), .AST_W(AST_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cur_ipl    (cur_ipl),
   .ast_req    (ast_req),
   .trap_ack   (trap_ack),
   .trap_pulse (trap_pulse),
   .isr_summary(isr_summary),
   .int_id     (int_id),
   .ast_err    (ast_err)
);

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] sw_req = '0, ext_req = '0;
   logic [4:0]  cur_ipl = '0;
   logic [3:0]  ast_req = '0;
   logic        trap_ack = 1'b0;
   logic        trap_pulse, ast_err;
   logic [31:0] isr_summary;
   logic [4:0]  int_id;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_level_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_req(ext_req),
      .cur_ipl(cur_ipl), .ast_req(ast_req), .trap_ack(trap_ack),
      .trap_pulse(trap_pulse), .isr_summary(isr_summary),
      .int_id(int_id), .ast_err(ast_err)
   );

   typedef struct packed {
      logic [31:0] sw;
      logic [31:0] ext;
      logic [4:0]  ipl;
      logic        trap;
      logic [4:0]  id;
      logic [31:0] sum;
      logic [3:0]  tag;   // requirement number exercised
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VT [NV] = '{
      '{32'h0000_0002, 32'h0,         5'd0,  1'b1, 5'd1,  32'h0000_0002, 4'd1},
      '{32'h0000_0208, 32'h0,         5'd0,  1'b1, 5'd9,  32'h0000_0208, 4'd1},
      '{32'h0000_0200, 32'h0,         5'd9,  1'b0, 5'd0,  32'h0,         4'd5},
      '{32'h0000_0200, 32'h0,         5'd8,  1'b1, 5'd9,  32'h0000_0200, 4'd5},
      '{32'h0000_8000, 32'h0010_0000, 5'd0,  1'b1, 5'd20, 32'h0010_8000, 4'd2},
      '{32'h0000_0008, 32'h0202_0000, 5'd24, 1'b1, 5'd25, 32'h0202_0008, 4'd4},
      '{32'h0,         32'h0200_0000, 5'd25, 1'b0, 5'd0,  32'h0,         4'd5},
      '{32'hFFFF_0001, 32'h0000_FFFF, 5'd0,  1'b0, 5'd0,  32'h0,         4'd3},
      '{32'h0000_8000, 32'h0,         5'd14, 1'b1, 5'd15, 32'h0000_8000, 4'd1},
      '{32'h0,         32'h8000_0000, 5'd30, 1'b1, 5'd31, 32'h8000_0000, 4'd2},
      '{32'h0000_8000, 32'h0001_0000, 5'd15, 1'b1, 5'd16, 32'h0001_8000, 4'd2},
      '{32'h0,         32'h8000_0000, 5'd31, 1'b0, 5'd0,  32'h0,         4'd5},
      '{32'h0,         32'h0,         5'd0,  1'b0, 5'd0,  32'h0,         4'd5}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string rname(input logic [3:0] t);
      case (t)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         default: return "R5";
      endcase
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [4:0]  exp_id;
      logic [31:0] exp_sum;
      int          pulses;
      exp_id = '0; exp_sum = '0;

      // R10: reset state
      ast_req = 4'h3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 trap", {31'b0, trap_pulse}, 32'h0);
      chk("R10 id", {27'b0, int_id}, 32'h0);
      chk("R10 sum", isr_summary, 32'h0);
      chk("R10 ast", {31'b0, ast_err}, 32'h0);
      ast_req = '0;
      rst_n = 1'b1;
      @(negedge clk);

      // vector table (R1..R5, R6, R7)
      for (int v = 0; v < NV; v++) begin
         sw_req = VT[v].sw; ext_req = VT[v].ext; cur_ipl = VT[v].ipl; trap_ack = 1'b0;
         @(posedge clk);
         @(negedge clk);
         if (VT[v].trap) begin
            exp_id = VT[v].id; exp_sum = VT[v].sum;
         end
         chk({rname(VT[v].tag), " R6 trap"}, {31'b0, trap_pulse}, {31'b0, VT[v].trap});
         chk({rname(VT[v].tag), " R7 id"}, {27'b0, int_id}, {27'b0, exp_id});
         chk({rname(VT[v].tag), " R4 sum"}, isr_summary, exp_sum);
         sw_req = '0; ext_req = '0; trap_ack = 1'b1;
         @(posedge clk);
         @(negedge clk);
         chk("R6 single", {31'b0, trap_pulse}, 32'h0);
         trap_ack = 1'b0;
      end

      // R8: held request without acknowledge gives only one trap
      sw_req = 32'h0000_0020; cur_ipl = 5'd0; pulses = 0;
      for (int c = 0; c < 5; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (trap_pulse) pulses++;
      end
      chk("R8 one pulse", pulses, 32'd1);
      chk("R8 id", {27'b0, int_id}, 32'd5);
      trap_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R8 ack edge", {31'b0, trap_pulse}, 32'h0);
      trap_ack = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R8 rearmed", {31'b0, trap_pulse}, 32'h1);
      sw_req = '0; trap_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      trap_ack = 1'b0;

      // R9: asynchronous-trap request only flags an error
      ast_req = 4'b0100;
      @(posedge clk);
      @(negedge clk);
      chk("R9 flag", {31'b0, ast_err}, 32'h1);
      chk("R9 no trap", {31'b0, trap_pulse}, 32'h0);
      chk("R9 id held", {27'b0, int_id}, 32'd5);
      ast_req = '0;
      @(posedge clk);
      @(negedge clk);
      chk("R9 clear", {31'b0, ast_err}, 32'h0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule